// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port

This block is a small memory-mapped I/O port for a microcontroller register bus. It serves four pins. Pins 0 to 2 are bidirectional, and pin 3 is input only. Software controls the port through four byte-wide registers:

- an output latch,
- a direction register,
- an analog-select register,
- a port view that returns the synchronized pin levels.

For each bidirectional pin the block drives an output-data signal and an output-enable signal. The pad itself sits outside the block. Every raw pin input passes through a two-flop synchronizer before any logic uses it.

A pin that is marked analog reads as zero in the port view. Its driver is still governed by its direction bit, so software must keep analog pins set as inputs. Pin 3 has no direction bit and no latch bit. A static configuration input chooses its role. With the input low, pin 3 is a plain digital input. With the input high, pin 3 is an active-low reset input: its port bit reads zero, and a reset request is raised while the synchronized level is low. The upper nibble of the direction register is kept for a separate parallel-port function. It is stored and read back but has no effect here.

Register addresses on `bus_addr`:

| Address | Register |
|---|---|
| 0 | port view |
| 1 | output latch |
| 2 | direction |
| 3 | analog select |

Writes take effect at the clock edge. Reads are combinational from the current state.

Top module: `gpio_quad_port`

## Requirements
- R1: While `rst_n` is low and after it is released, the registers hold their reset values:
  - direction bits [2:0] = 1 (inputs), direction bits [7:4] = 0,
  - latch = 0,
  - analog-select bits [2:0] = 1,
  - so `pin_oe` = 000 and port-view bits [2:0] read 0.
- R2: `pin_oe[i]` is the inverse of direction bit i, and `pin_out[i]` is latch bit i. A direction write at address 2 changes `pin_oe` after the next clock edge. Without a bus write, `pin_out` and `pin_oe` hold their values.
- R3: Port-view bit i (i < 3) reads 0 whenever analog-select bit i is 1. The analog-select register (address 3, bits [2:0]) does not alter `pin_oe`.
- R4: A read at address 1 returns the latch contents in bits [2:0], whatever level the pins carry.
- R5: A write at address 0 loads `bus_wdata[2:0]` into the latch, exactly as a write at address 1 does.
- R6: Port-view bits [2:0] return the pin levels (ANDed with the inverse of analog select) as sampled two clock edges earlier. A change on `pin_in` is not visible after one edge and is visible after the second edge.
- R7: With `cfg_rst_pin` = 0, port-view bit 3 is the synchronized `pin_in[3]` and `ext_rst_req` is 0. With `cfg_rst_pin` = 1, port-view bit 3 reads 0 and `ext_rst_req` is 1 exactly while synchronized `pin_in[3]` is 0. The pin-3 synchronizer resets to 1.
- R8: The direction register stores bits [7:4] and [2:0] and reads bit 3 as 0. Bits [7:4] never affect `pin_oe` or `pin_out`. Bit 3 of a latch or direction write is dropped.
- R9: Port view bits [7:4], and latch and analog-select bits [7:3], always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_rst_pin | input | 1 | Static: 1 makes pin 3 an active-low reset input |
| bus_addr | input | 2 | Register select (0 port view, 1 latch, 2 direction, 3 analog select) |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 4 | Raw pin levels, asynchronous |
| pin_out | output | 3 | Output data for pins 0 to 2 |
| pin_oe | output | 3 | Output enable for pins 0 to 2, 1 = drive |
| ext_rst_req | output | 1 | Reset request from pin 3 in reset mode |

## Verification
Two functions can fall in the same cycle:

1. A latch write, at address 0 or 1, arriving while a driven pin is forced to the opposite level on `pin_in`.
2. A direction or analog-select change landing in the same edge as a pin transition that is still inside the synchronizer.

The bench provokes both with back-to-back writes under toggling pin levels, and with a long random sequence of mixed writes, reads and pin changes. A behavioural model with its own two-entry sample queue judges every clock. It checks that the latch read reflects the write, not the pin, and that the port view shows the masked level from exactly two edges earlier.

// File: rtl/gpq_pkg.sv
package gpq_pkg;
    typedef enum logic [1:0] {
        GPQ_PORT = 2'd0,
        GPQ_LAT  = 2'd1,
        GPQ_DIR  = 2'd2,
        GPQ_ANS  = 2'd3
    } gpq_addr_e;

    localparam int GPQ_DATA_W = 8;
    localparam int GPQ_NBIDIR = 3;
endpackage

// File: rtl/gpq_sync.sv
module gpq_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpq_regs.sv
module gpq_regs
    import gpq_pkg::*;
#(
    parameter int NB = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    wr_addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [NB-1:0] dir_lo_q,
    output logic [3:0]    dir_hi_q,
    output logic [NB-1:0] lat_q,
    output logic [NB-1:0] ans_q
);
    gpq_addr_e sel;
    assign sel = gpq_addr_e'(wr_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_lo_q <= '1;
            dir_hi_q <= '0;
            lat_q    <= '0;
            ans_q    <= '1;
        end else if (wr_en) begin
            unique case (sel)
                GPQ_PORT,
                GPQ_LAT: lat_q <= wr_data[NB-1:0];
                GPQ_DIR: begin
                    dir_lo_q <= wr_data[NB-1:0];
                    dir_hi_q <= wr_data[DW-1:DW-4];
                end
                GPQ_ANS: ans_q <= wr_data[NB-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpq_rdmux.sv
module gpq_rdmux
    import gpq_pkg::*;
#(
    parameter int NB = 3,
    parameter int DW = 8
) (
    input  logic [1:0]    rd_addr,
    input  logic          rst_mode,
    input  logic [NB:0]   pins_sync,
    input  logic [NB-1:0] dir_lo,
    input  logic [3:0]    dir_hi,
    input  logic [NB-1:0] lat,
    input  logic [NB-1:0] ans,
    output logic [DW-1:0] rd_data
);
    localparam int PADW = DW - NB - 1;

    logic [NB-1:0] masked;
    logic          bit3;

    genvar i;
    generate
        for (i = 0; i < NB; i++) begin : g_mask
            assign masked[i] = pins_sync[i] & ~ans[i];
        end
    endgenerate

    assign bit3 = rst_mode ? 1'b0 : pins_sync[NB];

    always_comb begin
        rd_data = '0;
        unique case (gpq_addr_e'(rd_addr))
            GPQ_PORT: rd_data = {{PADW{1'b0}}, bit3, masked};
            GPQ_LAT:  rd_data = {{(DW-NB){1'b0}}, lat};
            GPQ_DIR:  rd_data = {dir_hi, {(DW-NB-4){1'b0}}, dir_lo};
            GPQ_ANS:  rd_data = {{(DW-NB){1'b0}}, ans};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_quad_port.sv
module gpio_quad_port
    import gpq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_rst_pin,
    input  logic [1:0]            bus_addr,
    input  logic                  bus_wr,
    input  logic [GPQ_DATA_W-1:0] bus_wdata,
    output logic [GPQ_DATA_W-1:0] bus_rdata,
    input  logic [GPQ_NBIDIR:0]   pin_in,
    output logic [GPQ_NBIDIR-1:0] pin_out,
    output logic [GPQ_NBIDIR-1:0] pin_oe,
    output logic                  ext_rst_req
);
    localparam int NB = GPQ_NBIDIR;
    localparam int DW = GPQ_DATA_W;
    localparam logic [NB:0] SYNC_RST = {1'b1, {NB{1'b0}}};

    logic [NB:0]   pins_sync;
    logic [NB-1:0] dir_lo_q;
    logic [3:0]    dir_hi_q;
    logic [NB-1:0] lat_q;
    logic [NB-1:0] ans_q;

    gpq_sync #(.W(NB+1), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pins_sync)
    );

    gpq_regs #(.NB(NB), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_addr  (bus_addr),
        .wr_en    (bus_wr),
        .wr_data  (bus_wdata),
        .dir_lo_q (dir_lo_q),
        .dir_hi_q (dir_hi_q),
        .lat_q    (lat_q),
        .ans_q    (ans_q)
    );

    gpq_rdmux #(.NB(NB), .DW(DW)) u_rdmux (
        .rd_addr   (bus_addr),
        .rst_mode  (cfg_rst_pin),
        .pins_sync (pins_sync),
        .dir_lo    (dir_lo_q),
        .dir_hi    (dir_hi_q),
        .lat       (lat_q),
        .ans       (ans_q),
        .rd_data   (bus_rdata)
    );

    assign pin_out     = lat_q;
    assign pin_oe      = ~dir_lo_q;
    assign ext_rst_req = cfg_rst_pin & ~pins_sync[NB];
endmodule

// File: rtl/gpq_chk.sv
module gpq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_rst_pin,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [2:0] pin_out,
    input logic [2:0] pin_oe,
    input logic       ext_rst_req,
    input logic [2:0] ans_q
);
    AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> (pin_oe == ~$past(bus_wdata[2:0]))); // R2

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe))); // R2

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1] == 1'b0) |=> (pin_out == $past(bus_wdata[2:0]))); // R5

    AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> ((bus_rdata[2:0] & ans_q) == 3'b000)); // R3

    AST_RSTPIN_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rst_pin && bus_addr == 2'd0) |-> (bus_rdata[3] == 1'b0)); // R7

    AST_RSTREQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_pin |-> !ext_rst_req); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 2'd2) |-> (bus_rdata[7:4] == 4'h0)); // R9
endmodule

bind gpio_quad_port gpq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rst_pin (cfg_rst_pin),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .ext_rst_req (ext_rst_req),
    .ans_q       (ans_q)
);

// File: tb/sim_gpio_quad_port.sv
`timescale 1ns/1ps
module sim_gpio_quad_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rst_pin = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in = 4'b1010;
    logic [2:0] pin_out;
    logic [2:0] pin_oe;
    logic       ext_rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_quad_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rst_pin(cfg_rst_pin),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .ext_rst_req(ext_rst_req)
    );

    // behavioural reference state
    int m_lat, m_dir_lo, m_dir_hi, m_ans;
    int pinq[$];

    function automatic int m_synced();
        return pinq[0];
    endfunction

    function automatic int m_read(input int a);
        int s;
        s = m_synced();
        case (a)
            0: return (s & 7 & ~m_ans) | ((cfg_rst_pin == 1'b0) ? (s & 8) : 0);
            1: return m_lat;
            2: return (m_dir_hi << 4) | m_dir_lo;
            default: return m_ans;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model update on every edge, comparison 2 ns later
    initial begin
        m_lat = 0; m_dir_lo = 7; m_dir_hi = 0; m_ans = 7;
        pinq = '{8, 8};
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                m_lat = 0; m_dir_lo = 7; m_dir_hi = 0; m_ans = 7;
                pinq = '{8, 8};
            end else begin
                pinq.push_back(int'(pin_in));
                void'(pinq.pop_front());
                if (bus_wr) begin
                    case (bus_addr)
                        2'd0, 2'd1: m_lat = bus_wdata & 7;
                        2'd2: begin m_dir_lo = bus_wdata & 7; m_dir_hi = bus_wdata >> 4; end
                        default: m_ans = bus_wdata & 7;
                    endcase
                end
            end
            #2;
            if (!done) begin
                chk(pin_oe == 3'(~m_dir_lo), "R2 oe", pin_oe, 3'(~m_dir_lo));
                chk(pin_out == 3'(m_lat), "R2 out", pin_out, m_lat);
                chk(ext_rst_req == (cfg_rst_pin && (m_synced() & 8) == 0),
                    "R7 rstreq", ext_rst_req, (cfg_rst_pin && (m_synced() & 8) == 0));
                chk(int'(bus_rdata) == m_read(bus_addr),
                    bus_addr == 0 ? "R6 port" : bus_addr == 1 ? "R4 latch" :
                    bus_addr == 2 ? "R8 dir" : "R3 ansel",
                    bus_rdata, m_read(bus_addr));
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        bus_addr = 2'(a);
        #1;
        chk(int'(bus_rdata) == exp, req, bus_rdata, exp);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values, checked while reset is still asserted
        rd_chk(2, 8'h07, "R1 dir reset");
        rd_chk(1, 8'h00, "R1 latch reset");
        rd_chk(3, 8'h07, "R1 ansel reset");
        rd_chk(0, 8'h08, "R1 port reset");
        chk(pin_oe == 3'b000, "R1 oe reset", pin_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk(0, 8'h08, "R3 analog pins read zero after reset");

        wr(3, 0);
        @(negedge clk);
        rd_chk(0, 8'h0A, "R6 digital pins visible");

        wr(2, 8'hFF);
        rd_chk(2, 8'hF7, "R8 dir bit3 reads zero, upper stored");
        chk(pin_oe == 3'b000, "R8 upper dir no pin effect", pin_oe, 0);
        wr(2, 8'hF5);
        chk(pin_oe == 3'b010, "R2 oe inverse of dir", pin_oe, 3'b010);

        wr(1, 8'hFD);
        rd_chk(1, 8'h05, "R9 latch upper zero, bit3 dropped");
        chk(pin_out == 3'b101, "R2 pin_out from latch", pin_out, 5);
        wr(0, 8'h02);
        rd_chk(1, 8'h02, "R5 port write loads latch");

        // latch read ignores opposing pin levels
        wr(2, 0);
        wr(1, 5);
        pin_in = 4'b1010;
        repeat (3) @(negedge clk);
        rd_chk(1, 8'h05, "R4 latch read not pin");

        wr(3, 8'h02);
        rd_chk(0, 8'h08, "R3 analog bit masked");
        chk(pin_oe == 3'b111, "R3 ansel leaves oe", pin_oe, 7);

        // synchronizer latency
        wr(3, 0);
        pin_in = 4'b0101;
        bus_addr = 2'd0;
        @(negedge clk);
        rd_chk(0, 8'h0A, "R6 not visible after one edge");
        @(negedge clk);
        rd_chk(0, 8'h05, "R6 visible after two edges");

        // reset-mode pin
        cfg_rst_pin = 1'b1;
        pin_in = 4'b1111;
        repeat (3) @(negedge clk);
        rd_chk(0, 8'h07, "R7 bit3 hidden in reset mode");
        chk(ext_rst_req == 1'b0, "R7 no request when high", ext_rst_req, 0);
        pin_in = 4'b0111;
        repeat (2) @(negedge clk);
        #1;
        chk(ext_rst_req == 1'b1, "R7 request when low", ext_rst_req, 1);
        cfg_rst_pin = 1'b0;
        #1;
        chk(ext_rst_req == 1'b0, "R7 digital mode no request", ext_rst_req, 0);

        // mixed random traffic, judged by the model each clock
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            bus_addr = 2'($urandom_range(0, 3));
            bus_wdata = 8'($urandom);
            bus_wr = 1'($urandom_range(0, 1));
            pin_in = 4'($urandom);
            if (k % 97 == 0) cfg_rst_pin = ~cfg_rst_pin;
        end
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule